// File: doc/BRIEF.md
# Multi-Word Transfer Sequencer

This block turns one double-word or multiple-register load/store command into a train of word-sized bus beats. A command carries a start byte address, a word count of 1 to 16, a direction, an endianness select and a strict-alignment enable. The sequencer walks the words at incrementing, word-aligned addresses. For stores, it reads each register word through a combinational register-file read port and puts it on the bus in the selected byte order. For loads, it converts each returned bus word into register order and presents it on a write-back strobe together with the word index.

The command port and the bus request port use valid/ready handshakes. The sequencer takes a command only while `cmd_ready` is high, which is whenever it is idle. It keeps a bus request and all of its fields unchanged until `req_ready` accepts it. Read data must be valid on `rsp_rdata` in the cycle of acceptance. Write-back has no back-pressure: the register file must take each `ld_valid` strobe. Completion and faults are reported on plain one-cycle pulses.

Top module: `mwt_seq`

## Requirements
- R1: The beat with index i (0 to count-1) goes to the aligned start address plus 4*i. The command finishes after exactly count beats, for counts from 1 to 16.
- R2: Every bus request has address bits [1:0] equal to zero.
- R3: On a load, the returned word is passed unchanged when the endian select is 0. When the select is 1, its four bytes are reversed (bus byte lane [7:0] holds the lowest address).
- R4: On a store, `rf_rd_idx` equals the beat index and `req_write` is 1. `req_wdata` is the register word unchanged when the endian select is 0, or byte-reversed when it is 1.
- R5: With strict checking on and start address bits [1:0] nonzero, the cycle after acceptance shows `fault`=1, `done`=1 and `fault_code`=2'b10 (alignment). The code 2'b01 (misaligned) is never produced. No bus request is issued.
- R6: While `req_valid` is high and `req_ready` is low, the next cycle keeps `req_valid` high with the same address, direction and write data.
- R7: `done` is high for exactly one cycle, the cycle after the last beat is accepted, with `busy` low and `fault` low.
- R8: `ld_valid` is high only in a cycle where a load beat is accepted, with `ld_idx` equal to the beat index. It never rises for a store.
- R9: With strict checking off, a misaligned start address is accepted, and the first beat goes to the address with bits [1:0] cleared.
- R10: After reset, `cmd_ready`=1, `busy`=0, `req_valid`=0, `done`=0 and `fault`=0.
- R11: A command presented while busy is not taken and does not change the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when both high (idle) |
| cmd_addr | input | AW | Start byte address |
| cmd_count | input | CW | Word count, 1..MAX_WORDS |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_big | input | 1 | 1 = big-endian byte order, 0 = little-endian |
| cmd_strict | input | 1 | Strict alignment checking enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Alignment fault pulse (with done) |
| fault_code | output | 2 | 2'b10 alignment, 2'b00 none |
| req_valid | output | 1 | Bus beat request |
| req_ready | input | 1 | Bus accepts the beat |
| req_addr | output | AW | Word-aligned beat address |
| req_write | output | 1 | Beat direction |
| req_wdata | output | DW | Store data in bus order |
| rsp_rdata | input | DW | Load data, valid in the accept cycle |
| rf_rd_idx | output | IW | Register word read index |
| rf_rd_data | input | DW | Register word for the store beat |
| ld_valid | output | 1 | Load write-back strobe |
| ld_idx | output | IW | Write-back word index |
| ld_data | output | DW | Load word in register order |

## Verification
Loads and stores are run in both byte orders against a memory of distinct byte values, so a lane swap, a missing swap or an off-by-one word shows up as a data or index mismatch. Counts of 1, 2, 3, 4, 5 and 16 exercise the first beat, the last beat and the full-length end of the index counter. A ready pattern that stalls every third cycle is mixed with always-ready runs, which separates a sequencer that waits for the handshake from one that runs freely. Misaligned starts are tried with strict checking on, which must fault with no bus traffic, and with it off, which must align down. A command injected mid-transfer must leave the beat stream untouched.

// File: rtl/mwt_pkg.sv
package mwt_pkg;
  typedef enum logic [1:0] {
    FLT_NONE     = 2'b00,
    FLT_MISALIGN = 2'b01,
    FLT_ALIGN    = 2'b10
  } flt_code_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_e;
endpackage

// File: rtl/mwt_bswap.sv
module mwt_bswap #(
  parameter int DW = 32
) (
  input  logic          swap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign dout[8*b +: 8] = swap ? din[8*(NB-1-b) +: 8] : din[8*b +: 8];
  end
endmodule

// File: rtl/mwt_ctrl.sv
module mwt_ctrl
  import mwt_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [CW-1:0] cmd_count,
  input  logic          cmd_store,
  input  logic          cmd_big,
  input  logic          cmd_strict,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [1:0]    fault_code,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          req_write,
  output logic [IW-1:0] beat_idx,
  output logic          beat_fire,
  output logic          big_q
);
  sq_state_e     state_q;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] last_q;
  logic          store_q;
  logic          done_q;
  logic          fault_q;
  logic          take;
  logic          misal;

  assign cmd_ready = (state_q == SQ_IDLE);
  assign take      = cmd_valid && cmd_ready;
  assign misal     = cmd_strict && (cmd_addr[1:0] != 2'b00);
  assign busy      = (state_q == SQ_RUN);
  assign req_valid = busy;
  assign req_addr  = addr_q;
  assign req_write = store_q;
  assign beat_idx  = idx_q;
  assign beat_fire = req_valid && req_ready;
  assign done      = done_q;
  assign fault     = fault_q;
  assign fault_code = fault_q ? FLT_ALIGN : FLT_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      store_q <= 1'b0;
      big_q   <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (take) begin
            if (misal) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
            end else begin
              state_q <= SQ_RUN;
              addr_q  <= {cmd_addr[AW-1:2], 2'b00};
              idx_q   <= '0;
              last_q  <= IW'(cmd_count - CW'(1));
              store_q <= cmd_store;
              big_q   <= cmd_big;
            end
          end
        end
        SQ_RUN: begin
          if (beat_fire) begin
            if (idx_q == last_q) begin
              state_q <= SQ_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q  <= idx_q + IW'(1);
              addr_q <= addr_q + AW'(4);
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && idx_q != last_q) |=> (req_valid && req_addr == $past(req_addr) + AW'(4))); // R1
  AST_FAULT_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && misal) |=> (fault && done && !req_valid && fault_code == 2'b10)); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && idx_q == last_q) |=> (done && !busy && !fault)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
endmodule

// File: rtl/mwt_seq.sv
module mwt_seq #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int MAX_WORDS = 16,
  localparam int CW       = $clog2(MAX_WORDS + 1),
  localparam int IW       = $clog2(MAX_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [CW-1:0] cmd_count,
  input  logic          cmd_store,
  input  logic          cmd_big,
  input  logic          cmd_strict,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [1:0]    fault_code,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          req_write,
  output logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] rsp_rdata,
  output logic [IW-1:0] rf_rd_idx,
  input  logic [DW-1:0] rf_rd_data,
  output logic          ld_valid,
  output logic [IW-1:0] ld_idx,
  output logic [DW-1:0] ld_data
);
  logic [IW-1:0] beat_idx;
  logic          beat_fire;
  logic          big_q;

  mwt_ctrl #(.AW(AW), .CW(CW), .IW(IW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_addr   (cmd_addr),
    .cmd_count  (cmd_count),
    .cmd_store  (cmd_store),
    .cmd_big    (cmd_big),
    .cmd_strict (cmd_strict),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .beat_idx   (beat_idx),
    .beat_fire  (beat_fire),
    .big_q      (big_q)
  );

  mwt_bswap #(.DW(DW)) u_st_swap (
    .swap (big_q),
    .din  (rf_rd_data),
    .dout (req_wdata)
  );

  mwt_bswap #(.DW(DW)) u_ld_swap (
    .swap (big_q),
    .din  (rsp_rdata),
    .dout (ld_data)
  );

  assign rf_rd_idx = beat_idx;
  assign ld_idx    = beat_idx;
  assign ld_valid  = beat_fire && !req_write;

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[1:0] == 2'b00)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write))); // R6
  AST_LD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (req_valid && req_ready && !req_write)); // R8
  AST_NO_WB_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> !ld_valid); // R8
endmodule

// File: tb/mwt_seq_test.sv
module mwt_seq_test;
  localparam int AW = 32;
  localparam int DW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [4:0]  cmd_count = '0;
  logic        cmd_store = 1'b0;
  logic        cmd_big = 1'b0;
  logic        cmd_strict = 1'b0;
  logic        busy, done, fault;
  logic [1:0]  fault_code;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr, req_wdata, rsp_rdata, rf_rd_data, ld_data;
  logic        req_write;
  logic [3:0]  rf_rd_idx, ld_idx;
  logic        ld_valid;

  logic [31:0] mem [0:63];
  logic [31:0] rf  [0:15];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit stall = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic        wr;
    logic [31:0] data;
    logic [3:0]  idx;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign rsp_rdata  = mem[req_addr[7:2]];
  assign rf_rd_data = rf[rf_rd_idx];

  mwt_seq #(.AW(AW), .DW(DW), .MAX_WORDS(16)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_count(cmd_count), .cmd_store(cmd_store), .cmd_big(cmd_big),
    .cmd_strict(cmd_strict), .busy(busy), .done(done), .fault(fault),
    .fault_code(fault_code), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data)
  );

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected beats as the design completes them
  initial begin
    bit          prev_hold = 1'b0;
    logic [31:0] prev_addr = '0;
    logic        prev_wr = 1'b0;
    forever begin
      @(negedge clk);
      req_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (rst_n) begin
        if (prev_hold) begin
          chk(req_valid && req_addr == prev_addr && req_write == prev_wr,
              "R6", "stalled beat changed", req_addr, prev_addr);
        end
        if (req_valid) chk(req_addr[1:0] == 2'b00, "R2", "beat address low bits", req_addr, {req_addr[31:2], 2'b00});
        if (req_valid && req_ready) begin
          if (q.size() == 0) begin
            chk(1'b0, "R1", "unexpected beat", req_addr, 32'hFFFF_FFFF);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(req_addr == e.addr, "R1", "beat address", req_addr, e.addr);
            chk(req_write == e.wr, "R4", "beat direction", {31'd0, req_write}, {31'd0, e.wr});
            if (e.wr) begin
              chk(rf_rd_idx == e.idx, "R4", "register read index", {28'd0, rf_rd_idx}, {28'd0, e.idx});
              chk(req_wdata == e.data, "R4", "store data", req_wdata, e.data);
              chk(!ld_valid, "R8", "write-back on store", {31'd0, ld_valid}, 32'd0);
              mem[req_addr[7:2]] = req_wdata;
            end else begin
              chk(ld_valid, "R8", "write-back strobe", {31'd0, ld_valid}, 32'd1);
              chk(ld_idx == e.idx, "R8", "write-back index", {28'd0, ld_idx}, {28'd0, e.idx});
              chk(ld_data == e.data, "R3", "load data", ld_data, e.data);
            end
          end
        end else if (ld_valid) begin
          chk(1'b0, "R8", "strobe without beat", 32'd1, 32'd0);
        end
        prev_hold = req_valid && !req_ready;
        prev_addr = req_addr;
        prev_wr   = req_write;
      end
    end
  end

  // driver: pushes expected beats, issues the command, waits for completion
  task automatic run_cmd(input logic [31:0] a, input int n, input bit st,
                         input bit bg, input bit sc, input bit exp_fault,
                         input bit inject);
    int waits;
    if (!exp_fault) begin
      for (int i = 0; i < n; i++) begin
        exp_t e;
        e.addr = {a[31:2], 2'b00} + 32'(4 * i);
        e.wr   = st;
        e.idx  = 4'(i);
        if (st) e.data = bg ? rev(rf[i]) : rf[i];
        else    e.data = bg ? rev(mem[e.addr[7:2]]) : mem[e.addr[7:2]];
        q.push_back(e);
      end
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_count = 5'(n);
    cmd_store = st; cmd_big = bg; cmd_strict = sc;
    @(negedge clk);
    cmd_valid = 1'b0;
    waits = 1;
    #2;
    while (!done) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      #2;
      waits++;
      if (inject && waits == 3) begin
        // R11: command offered mid-transfer must be ignored
        chk(!cmd_ready, "R11", "ready while busy", {31'd0, cmd_ready}, 32'd0);
        cmd_valid = 1'b1; cmd_addr = 32'h0000_0084; cmd_count = 5'd2;
        cmd_store = ~st; cmd_big = ~bg; cmd_strict = 1'b0;
      end
    end
    cmd_valid = 1'b0;
    chk(fault == exp_fault, "R5", "fault flag", {31'd0, fault}, {31'd0, exp_fault});
    if (exp_fault) begin
      chk(waits == 1, "R5", "fault latency", 32'(waits), 32'd1);
      chk(fault_code == 2'b10, "R5", "fault code", {30'd0, fault_code}, 32'd2);
      chk(!req_valid, "R5", "request on fault", {31'd0, req_valid}, 32'd0);
    end
    chk(q.size() == 0, "R7", "beats left at done", 32'(q.size()), 32'd0);
    chk(!busy, "R7", "busy at done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    #2;
    chk(!done, "R7", "done longer than a cycle", {31'd0, done}, 32'd0);
    chk(!req_valid, "R11", "stray transfer after done", {31'd0, req_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R7 watchdog expired act=%0d exp=%0d", 100000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++)
      mem[i] = {8'(4 * i + 3) ^ 8'hA0, 8'(4 * i + 2), 8'(4 * i + 1) ^ 8'h50, 8'(4 * i)};
    for (int i = 0; i < 16; i++)
      rf[i] = {8'(i) | 8'hC0, 8'(i + 16), 8'(i + 32) ^ 8'h0F, 8'(i + 48)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(cmd_ready && !busy && !req_valid && !done && !fault, "R10", "reset state",
        {27'd0, cmd_ready, busy, req_valid, done, fault}, 32'h10);

    run_cmd(32'h10, 4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);  // R3 little-endian load
    run_cmd(32'h20, 3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);  // R3 big-endian load
    run_cmd(32'h80, 2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);  // R4 little-endian store
    run_cmd(32'h90, 5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);  // R4 big-endian store
    run_cmd(32'h90, 5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);  // R3 read back in big-endian
    run_cmd(32'h40, 16, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R1 full count
    run_cmd(32'h08, 1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);  // R1 single word
    run_cmd(32'h32, 2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);  // R5 strict fault on store
    run_cmd(32'h05, 3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);  // R5 strict fault on load
    run_cmd(32'h13, 2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);  // R9 non-strict align-down
    run_cmd(32'h50, 4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);  // R11 injection mid-transfer
    stall = 1'b1;
    run_cmd(32'hA0, 6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);  // R6 store under stalls
    run_cmd(32'hA0, 6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);  // R6 load under stalls
    run_cmd(32'h00, 16, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R1 full count with stalls
    stall = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule